// File: doc/BRIEF.md
# 64-bit Integer ALU with 32-bit Word Mode

This block is the combinational integer execution unit of a 64-bit processor pipeline. It takes an operation select, two 64-bit operands, an optional 12-bit immediate and a word-mode flag. It returns a 64-bit result in the same cycle. It covers addition, subtraction, the bitwise logic operations, signed and unsigned set-less-than, and logical and arithmetic shifts.

When `word_mode` is set, only the low 32 bits of the operands are used, and shift counts are limited to 5 bits. The 32-bit result is then sign-extended to 64 bits. When `use_imm` is set, the sign-extended 12-bit immediate takes the place of the second operand. Any combination of select, mode and immediate that the unit does not define gives a zero result and raises `illegal_op`.

Top module: `alu_rv64`

## Requirements
- R1: Operation code 0 (add) returns `src_a + B` and code 1 (subtract) returns `src_a - B`, both modulo 2^64. B is `src_b`, or the sign-extended immediate when `use_imm` is 1. Subtract is defined only with `use_imm` = 0.
- R2: Codes 5 (xor), 8 (or) and 9 (and) return the bitwise function of `src_a` and B.
- R3: Code 3 returns 1 when `src_a` < B as two's-complement numbers, and code 4 returns 1 when `src_a` < B as unsigned numbers. Otherwise each returns 0. Bits 63..1 of the result are always zero.
- R4: With `use_imm` = 1, B is `imm12` sign-extended to 64 bits for every operation, including the logic operations and the unsigned compare.
- R5: Outside word mode, codes 2 (shift left), 6 (logical shift right) and 7 (arithmetic shift right) shift by the low 6 bits of B. Higher bits of B are ignored.
- R6: Outside word mode, the arithmetic right shift fills vacated bits with bit 63 of `src_a`, and the logical right shift fills them with zeros.
- R7: In word mode, add, subtract and add-immediate use only bits 31..0 of the operands. The result is the low 32 bits of the sum or difference, sign-extended from bit 31 to 64 bits.
- R8: In word mode, the three shifts use bits 31..0 of `src_a` and the low 5 bits of B. The arithmetic shift fills from bit 31. Every word shift result, including a shift by zero, is sign-extended from bit 31.
- R9: These cases drive `illegal_op` to 1 and `result` to zero: codes 10 to 15; word mode with codes 3, 4, 5, 8 or 9; and code 1 with `use_imm` = 1. Every other case drives `illegal_op` to 0.
- R10: The unit is combinational, so `result` and `illegal_op` follow the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 sll, 3 slt, 4 sltu, 5 xor, 6 srl, 7 sra, 8 or, 9 and) |
| word_mode | input | 1 | 1 selects 32-bit word operation with sign-extended result |
| use_imm | input | 1 | 1 replaces `src_b` with the sign-extended `imm12` |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm12 | input | 12 | Immediate operand |
| result | output | 64 | Operation result |
| illegal_op | output | 1 | High for an undefined combination of operation, mode and immediate |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- Shift counts with bit 6 or bit 5 set. A unit that does not mask the count would shift everything out.
- A word shift left into bit 31, and a word shift right by zero of a value with bit 31 set. A unit that forgets the final sign extension would leave the upper half at zero.
- Word operations with garbage in the upper operand halves. Leaking that garbage through shows up in the result.
- Compare pairs that straddle the sign boundary, where swapping the signed and unsigned compares flips the answer.
- An and-immediate with a negative immediate. A unit that zero-extends immediates would clear the upper 52 bits.
- Every illegal combination. A unit that decodes them loosely would return a nonzero value with the flag low.

// File: rtl/alu_rv64_pkg.sv
package alu_rv64_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SLT  = 4'd3,
        OP_SLTU = 4'd4,
        OP_XOR  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_OR   = 4'd8,
        OP_AND  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LOGIC_XOR = 2'd0,
        LOGIC_OR  = 2'd1,
        LOGIC_AND = 2'd2
    } logic_fn_e;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]         src_a,
    input  logic [XLEN-1:0]         src_b,
    input  logic [IMM_W-1:0]        imm,
    input  logic                    use_imm,
    input  logic                    word_mode,
    input  logic                    arith_shift,
    output logic [XLEN-1:0]         opnd_b,
    output logic [XLEN-1:0]         shift_src,
    output logic [$clog2(XLEN)-1:0] shift_amt
);
    localparam int SHW   = $clog2(XLEN);
    localparam int WSHW  = $clog2(WLEN);
    localparam int UPPER = XLEN - WLEN;

    logic [XLEN-1:0] imm_ext;
    logic [SHW-1:0]  amt_raw;

    always_comb begin
        imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        opnd_b  = use_imm ? imm_ext : src_b;
        amt_raw = opnd_b[SHW-1:0];
        if (word_mode) begin
            shift_amt = {{(SHW-WSHW){1'b0}}, amt_raw[WSHW-1:0]};
            if (arith_shift) begin
                shift_src = {{UPPER{src_a[WLEN-1]}}, src_a[WLEN-1:0]};
            end else begin
                shift_src = {{UPPER{1'b0}}, src_a[WLEN-1:0]};
            end
        end else begin
            shift_amt = amt_raw;
            shift_src = src_a;
        end
    end
endmodule

// File: rtl/alu_addcmp.sv
module alu_addcmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            do_sub,
    output logic [XLEN-1:0] sum,
    output logic            less_signed,
    output logic            less_unsigned
);
    logic [XLEN:0]   wide_sum;
    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff         = do_sub ? ~opnd_b : opnd_b;
        wide_sum      = {1'b0, opnd_a} + {1'b0, b_eff} + {{XLEN{1'b0}}, do_sub};
        sum           = wide_sum[XLEN-1:0];
        less_unsigned = ~wide_sum[XLEN];
        if (opnd_a[XLEN-1] != opnd_b[XLEN-1]) begin
            less_signed = opnd_a[XLEN-1];
        end else begin
            less_signed = wide_sum[XLEN-1];
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         shift_in,
    input  logic [$clog2(XLEN)-1:0] amount,
    input  logic                    go_right,
    input  logic                    arith,
    output logic [XLEN-1:0]         shift_out
);
    localparam int STAGES = $clog2(XLEN);

    logic [XLEN-1:0] stage_v [STAGES+1];
    logic            fill_bit;

    assign fill_bit   = arith & shift_in[XLEN-1];
    assign stage_v[0] = shift_in;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int DIST = 1 << k;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (go_right) begin
                moved = {{DIST{fill_bit}}, stage_v[k][XLEN-1:DIST]};
            end else begin
                moved = {stage_v[k][XLEN-1-DIST:0], {DIST{1'b0}}};
            end
        end
        assign stage_v[k+1] = amount[k] ? moved : stage_v[k];
    end

    assign shift_out = stage_v[STAGES];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_rv64_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic_fn_e       fn,
    output logic [XLEN-1:0] logic_out
);
    always_comb begin
        unique case (fn)
            LOGIC_OR:  logic_out = opnd_a | opnd_b;
            LOGIC_AND: logic_out = opnd_a & opnd_b;
            default:   logic_out = opnd_a ^ opnd_b;
        endcase
    end
endmodule

// File: rtl/alu_rv64.sv
module alu_rv64
    import alu_rv64_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [3:0]       op_sel,
    input  logic             word_mode,
    input  logic             use_imm,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm12,
    output logic [XLEN-1:0]  result,
    output logic             illegal_op
);
    localparam int SHW   = $clog2(XLEN);
    localparam int UPPER = XLEN - WLEN;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            bad;
    } alu_out_t;

    alu_op_e         op;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] shift_src;
    logic [SHW-1:0]  shift_amt;
    logic [XLEN-1:0] sum;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] logic_res;
    logic_fn_e       logic_fn;
    logic            is_sub;
    logic            is_arith;
    logic            is_right;
    alu_out_t        out_d;

    assign op       = alu_op_e'(op_sel);
    assign is_sub   = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    assign is_arith = (op == OP_SRA);
    assign is_right = (op == OP_SRL) || (op == OP_SRA);

    always_comb begin
        case (op)
            OP_OR:   logic_fn = LOGIC_OR;
            OP_AND:  logic_fn = LOGIC_AND;
            default: logic_fn = LOGIC_XOR;
        endcase
    end

    alu_operand_prep #(.XLEN(XLEN), .WLEN(WLEN), .IMM_W(IMM_W)) u_prep (
        .src_a       (src_a),
        .src_b       (src_b),
        .imm         (imm12),
        .use_imm     (use_imm),
        .word_mode   (word_mode),
        .arith_shift (is_arith),
        .opnd_b      (opnd_b),
        .shift_src   (shift_src),
        .shift_amt   (shift_amt)
    );

    alu_addcmp #(.XLEN(XLEN)) u_addcmp (
        .opnd_a        (src_a),
        .opnd_b        (opnd_b),
        .do_sub        (is_sub),
        .sum           (sum),
        .less_signed   (lt_s),
        .less_unsigned (lt_u)
    );

    alu_shifter #(.XLEN(XLEN)) u_shift (
        .shift_in  (shift_src),
        .amount    (shift_amt),
        .go_right  (is_right),
        .arith     (is_arith),
        .shift_out (shifted)
    );

    alu_logic #(.XLEN(XLEN)) u_logic (
        .opnd_a    (src_a),
        .opnd_b    (opnd_b),
        .fn        (logic_fn),
        .logic_out (logic_res)
    );

    always_comb begin
        logic [XLEN-1:0] raw;
        logic            word_ok;
        raw     = '0;
        word_ok = 1'b0;
        out_d   = '0;
        out_d.bad = 1'b0;
        case (op)
            OP_ADD:  begin raw = sum;       word_ok = 1'b1; end
            OP_SUB:  begin raw = sum;       word_ok = 1'b1; end
            OP_SLL:  begin raw = shifted;   word_ok = 1'b1; end
            OP_SRL:  begin raw = shifted;   word_ok = 1'b1; end
            OP_SRA:  begin raw = shifted;   word_ok = 1'b1; end
            OP_SLT:  raw = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: raw = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR, OP_OR, OP_AND: raw = logic_res;
            default: out_d.bad = 1'b1;
        endcase
        if (word_mode && !word_ok) begin
            out_d.bad = 1'b1;
        end
        if (op == OP_SUB && use_imm) begin
            out_d.bad = 1'b1;
        end
        if (out_d.bad) begin
            out_d.value = '0;
        end else if (word_mode) begin
            out_d.value = {{UPPER{raw[WLEN-1]}}, raw[WLEN-1:0]};
        end else begin
            out_d.value = raw;
        end
    end

    assign result     = out_d.value;
    assign illegal_op = out_d.bad;
endmodule

// File: rtl/alu_rv64_chk.sv
module alu_rv64_chk
    import alu_rv64_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int WLEN  = 32,
    parameter int IMM_W = 12
) (
    input logic [3:0]       op_sel,
    input logic             word_mode,
    input logic             use_imm,
    input logic [XLEN-1:0]  src_a,
    input logic [XLEN-1:0]  src_b,
    input logic [IMM_W-1:0] imm12,
    input logic [XLEN-1:0]  result,
    input logic             illegal_op
);
    logic known;
    assign known = !$isunknown({op_sel, word_mode, use_imm, src_a, src_b, imm12, result, illegal_op});

    always_comb begin
        if (known) begin
            assert_illegal_zero_R9: assert (!illegal_op || result == '0)
                else $error("illegal op produced nonzero result");
            assert_undef_code_R9: assert (op_sel < 4'd10 || illegal_op)
                else $error("undefined code not flagged");
            assert_cmp_boolean_R3: assert (illegal_op ||
                    !(op_sel == OP_SLT || op_sel == OP_SLTU) || result[XLEN-1:1] == '0)
                else $error("compare result not 0/1");
            assert_word_sext_R7: assert (!word_mode || illegal_op ||
                    result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}})
                else $error("word result not sign-extended");
            assert_sll_zero_R5: assert (!(op_sel == OP_SLL && !word_mode && !use_imm &&
                    src_b[$clog2(XLEN)-1:0] == '0) || result == src_a)
                else $error("shift by zero changed value");
            assert_sub_self_R1: assert (!(op_sel == OP_SUB && !use_imm && src_a == src_b)
                    || result == '0)
                else $error("x - x not zero");
        end
    end
endmodule

bind alu_rv64 alu_rv64_chk #(.XLEN(XLEN), .WLEN(WLEN), .IMM_W(IMM_W)) u_chk (
    .op_sel     (op_sel),
    .word_mode  (word_mode),
    .use_imm    (use_imm),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm12      (imm12),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/sim_alu_rv64.sv
module sim_alu_rv64;
    localparam int VW = 215;
    localparam int NV = 32;

    logic        clk = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        word_mode = 1'b0;
    logic        use_imm = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [11:0] imm12 = '0;
    logic [63:0] result;
    logic        illegal_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu_rv64 u0 (
        .op_sel     (op_sel),
        .word_mode  (word_mode),
        .use_imm    (use_imm),
        .src_a      (src_a),
        .src_b      (src_b),
        .imm12      (imm12),
        .result     (result),
        .illegal_op (illegal_op)
    );

    function automatic logic [VW-1:0] vec(input logic [3:0] req, input logic [3:0] op,
            input logic w, input logic im, input logic [63:0] a, input logic [63:0] b,
            input logic [11:0] i, input logic [63:0] e, input logic ill);
        return {req, op, w, im, a, b, i, e, ill};
    endfunction

    localparam logic [VW-1:0] VECS [NV] = '{
        vec(1, 0, 0, 0, 64'd5, 64'd7, 12'h0, 64'd12, 0),                                    // R1
        vec(1, 1, 0, 0, 64'd3, 64'd5, 12'h0, 64'hFFFF_FFFF_FFFF_FFFE, 0),                   // R1
        vec(1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'h0, 64'd0, 0),                   // R1
        vec(2, 5, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 12'h0, 64'h0FF0_0FF0_0FF0_0FF0, 0), // R2
        vec(2, 8, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 12'h0, 64'h0FFF_0FFF_0FFF_0FFF, 0), // R2
        vec(2, 9, 0, 0, 64'h00FF_00FF_00FF_00FF, 64'h0F0F_0F0F_0F0F_0F0F, 12'h0, 64'h000F_000F_000F_000F, 0), // R2
        vec(3, 3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'h0, 64'd1, 0),                   // R3
        vec(3, 4, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 12'h0, 64'd0, 0),                   // R3
        vec(3, 3, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 64'd0, 0),                   // R3
        vec(3, 4, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 64'd1, 0),                   // R3
        vec(4, 0, 0, 1, 64'd10, 64'd999, 12'hFFF, 64'd9, 0),                                // R4
        vec(4, 4, 0, 1, 64'd5, 64'd0, 12'hFFF, 64'd1, 0),                                   // R4
        vec(4, 9, 0, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 12'h800, 64'h1234_5678_9ABC_D800, 0), // R4
        vec(4, 5, 0, 1, 64'd0, 64'hFFFF, 12'h7FF, 64'h7FF, 0),                              // R4
        vec(5, 2, 0, 0, 64'd1, 64'h41, 12'h0, 64'd2, 0),                                    // R5
        vec(5, 6, 0, 0, 64'h8000_0000_0000_0000, 64'd63, 12'h0, 64'd1, 0),                  // R5
        vec(6, 7, 0, 1, 64'h8000_0000_0000_0000, 64'd0, 12'h004, 64'hF800_0000_0000_0000, 0), // R6
        vec(6, 7, 0, 0, 64'h4000_0000_0000_0000, 64'd4, 12'h0, 64'h0400_0000_0000_0000, 0), // R6
        vec(7, 0, 1, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 12'h0, 64'hFFFF_FFFF_8000_0000, 0), // R7
        vec(7, 0, 1, 0, 64'hFFFF_FFFF_0000_0005, 64'h1234_5678_0000_0003, 12'h0, 64'd8, 0), // R7
        vec(7, 1, 1, 0, 64'd0, 64'd1, 12'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0),                   // R7
        vec(7, 0, 1, 1, 64'h0000_0001_0000_0000, 64'd0, 12'hFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0), // R7
        vec(8, 2, 1, 0, 64'd1, 64'h21, 12'h0, 64'd2, 0),                                    // R8
        vec(8, 2, 1, 1, 64'd1, 64'd0, 12'h01F, 64'hFFFF_FFFF_8000_0000, 0),                 // R8
        vec(8, 6, 1, 0, 64'hFFFF_FFFF_8000_0000, 64'd4, 12'h0, 64'h0000_0000_0800_0000, 0), // R8
        vec(8, 7, 1, 0, 64'h0000_0000_8000_0000, 64'd4, 12'h0, 64'hFFFF_FFFF_F800_0000, 0), // R8
        vec(8, 7, 1, 1, 64'hFFFF_FFFF_7000_0000, 64'd0, 12'h004, 64'h0000_0000_0700_0000, 0), // R8
        vec(8, 6, 1, 0, 64'h0000_0000_8000_0000, 64'd0, 12'h0, 64'hFFFF_FFFF_8000_0000, 0), // R8
        vec(9, 10, 0, 0, 64'd5, 64'd7, 12'h0, 64'd0, 1),                                    // R9
        vec(9, 15, 0, 0, 64'd5, 64'd7, 12'h0, 64'd0, 1),                                    // R9
        vec(9, 5, 1, 0, 64'd5, 64'd7, 12'h0, 64'd0, 1),                                     // R9
        vec(9, 1, 0, 1, 64'd5, 64'd7, 12'h001, 64'd0, 1)                                    // R9
    };

    task automatic check(input int req, input logic [63:0] exp_res, input logic exp_ill);
        checks++;
        if (result !== exp_res || illegal_op !== exp_ill) begin
            fails++;
            $display("FAIL R%0d: result=%h illegal=%b expected result=%h illegal=%b",
                     req, result, illegal_op, exp_res, exp_ill);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end

    initial begin
        // Idle state: add of zeros gives zero, no flag (R1, R9)
        @(negedge clk);
        check(1, 64'd0, 1'b0);

        for (int n = 0; n < NV; n++) begin
            @(posedge clk);
            #1;
            op_sel    = VECS[n][210:207];
            word_mode = VECS[n][206];
            use_imm   = VECS[n][205];
            src_a     = VECS[n][204:141];
            src_b     = VECS[n][140:77];
            imm12     = VECS[n][76:65];
            @(negedge clk);
            check(int'(VECS[n][214:211]), VECS[n][64:1], VECS[n][0]);
        end

        // R10: result follows inputs between clock edges
        @(negedge clk);
        #1;
        op_sel = 4'd0; word_mode = 1'b0; use_imm = 1'b0;
        src_a = 64'd100; src_b = 64'd23;
        #1;
        check(10, 64'd123, 1'b0);
        src_b = 64'd1;
        #1;
        check(10, 64'd101, 1'b0);

        // R4: immediate replaces src_b for the unsigned compare; src_b is ignored
        op_sel = 4'd4; use_imm = 1'b1; src_a = 64'hFFFF_FFFF_FFFF_FFF0;
        src_b = 64'd0; imm12 = 12'hFFF;
        #1;
        check(4, 64'd1, 1'b0);

        // R5: bit 6 of the register shift count is ignored
        op_sel = 4'd6; use_imm = 1'b0; src_a = 64'hF0; src_b = 64'h44;
        #1;
        check(5, 64'h0F, 1'b0);

        // R9: word-mode compare is undefined
        op_sel = 4'd3; word_mode = 1'b1;
        #1;
        check(9, 64'd0, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule